// File: doc/BRIEF.md
# Preloadable Event Counter Bank with Overflow Interrupt

A bank of 28-bit performance counters sits behind a 32-bit register port with a single write strobe and a combinational read path. Slot 0 advances on every clock. Slot 1 advances on a dedicated wasted-cycle input. Each slot from 2 upward has a 5-bit selector that picks one line of a 32-wide event vector. A slot advances by one on each clock where its event is high, provided both its own run bit and the bank-wide run bit are set.

To get an interrupt after a chosen number of events, software stops a slot and writes a start value into it. When the slot then steps from the all-ones value to zero, it sets its bit in a sticky overflow status word. The `irq` output is a level signal. It is high while the bank-wide interrupt bit is set and at least one status bit is set whose slot has its interrupt bit set. Status bits clear only when 1 is written to them through the clear register. A separate set register can force status bits for test. Any write to the bank-clear register zeroes every counter and every status bit.

Top module: `evc_bank`

## Requirements
- R1: Register offsets, word-aligned, with address bits [1:0] ignored:
  - 0x000 reads the constant 0x00010000.
  - 0x008 is bank control: bit 0 is run, bit 1 is interrupt enable.
  - 0x00C is bank clear.
  - 0x030 is overflow status, with bit n for slot n.
  - 0x034 is write-1 clear of status.
  - 0x03C is write-1 set of status.
  - 0x040+4n is the value of slot n.
  - 0x100+4n is the control of slot n: bit 0 is run, bit 1 is interrupt enable.
  - 0x140+4n is the event selector of slot n.
  - Any other offset, and the clear, write-1 clear and write-1 set registers, read 0.
- R2: Slot 0 advances by one on every clock edge at which its run bit and the bank run bit are both 1.
- R3: Slot 1 advances by one on every clock edge at which `wasted_in` is high and both run bits are 1.
- R4: A slot n≥2 advances on edges where `evt_in[sel]` is high, `sel` being the low 5 bits of its selector. Events on other lines do not move it. Slots 0 and 1 have no selector: writes to their selector offsets are dropped, and those offsets read 0.
- R5: A slot does not change while either its run bit or the bank run bit is 0. Writing 0 to a slot's control stops it and removes it from the interrupt.
- R6: A value write loads bits [27:0] of the write data, and reads return the value zero-extended to 32 bits. After loading P, the (0x0FFFFFFF−P+1)-th counted event takes the slot to 0.
- R7: The step from 0x0FFFFFFF to 0 sets status bit n. The bit then stays set until 1 is written to bit n of the clear register. Writing 1 to bit n of the set register forces the bit high. Writes of 0 leave bits unchanged.
- R8: `irq` equals the bank interrupt enable ANDed with the OR over n of (status bit n AND the interrupt enable of slot n).
- R9: A write to the bank-clear register zeroes all slot values and all status bits. It leaves control and selector registers unchanged.
- R10: After `rst_n` is low, all registers read 0 (except the constant) and `irq` is low.
- R11: If a wrap and a write-1 clear of the same status bit happen on the same edge, the bit ends set. A value write on the same edge as a counted event wins, and the event is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, one write per cycle it is high |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | 32 | Single-cycle event lines for selectable slots |
| wasted_in | input | 1 | Wasted-cycle indication for slot 1 |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check properties that hold on every cycle:
- a slot moves by exactly one when it counts, and holds its value otherwise;
- a bank clear leaves every slot at zero;
- a wrap always leaves its status bit set;
- status bits never drop without a clear write;
- `irq` never rises without a status bit behind it.

Only the bench scenarios can show that the event selection, the preload-to-wrap distance, the address decode and the interrupt masking produce the values software expects. The bench sweeps every selector value and several run windows for this.

// File: rtl/evc_pkg.sv
package evc_pkg;

   // register offsets (byte addresses)
   localparam logic [11:0] OFS_IDENT   = 12'h000;
   localparam logic [11:0] OFS_BCTL    = 12'h008;
   localparam logic [11:0] OFS_BCLR    = 12'h00C;
   localparam logic [11:0] OFS_OVF     = 12'h030;
   localparam logic [11:0] OFS_OVF_W1C = 12'h034;
   localparam logic [11:0] OFS_OVF_W1S = 12'h03C;

   // 64-byte windows, selected by address bits [11:6]
   localparam logic [5:0] WIN_VALUE = 6'h01;   // 0x040
   localparam logic [5:0] WIN_CTL   = 6'h04;   // 0x100
   localparam logic [5:0] WIN_SEL   = 6'h05;   // 0x140

   localparam logic [31:0] IDENT_VALUE = 32'h0001_0000;

   typedef struct packed {
      logic ie;    // bit 1
      logic run;   // bit 0
   } ctl_t;

endpackage

// File: rtl/evc_slot.sv
module evc_slot #(
   parameter int CNT_W   = 28,
   parameter int EVT_W   = 32,
   parameter int SEL_W   = 5,
   parameter bit HAS_SEL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [EVT_W-1:0] evt_vec,
   input  logic             fixed_evt,
   input  logic             ld_val,
   input  logic [CNT_W-1:0] ld_data,
   input  logic             ld_sel,
   input  logic [SEL_W-1:0] sel_data,
   input  logic             clr_all,
   output logic [CNT_W-1:0] val_o,
   output logic [SEL_W-1:0] sel_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] val_q;
   logic             evt_now;
   logic             inc;

   generate
      if (HAS_SEL) begin : g_sel
         logic [SEL_W-1:0] sel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sel_q <= '0;
            else if (ld_sel) sel_q <= sel_data;
         end
         assign evt_now = evt_vec[sel_q];
         assign sel_o   = sel_q;
         logic unused_fixed;
         assign unused_fixed = fixed_evt;
      end else begin : g_fixed
         assign evt_now = fixed_evt;
         assign sel_o   = '0;
         logic unused_sel;
         assign unused_sel = ld_sel ^ (^sel_data) ^ (^evt_vec);
      end
   endgenerate

   assign inc    = run_en & evt_now;
   assign wrap_o = inc & (val_q == TOP) & ~ld_val & ~clr_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       val_q <= '0;
      else if (clr_all) val_q <= '0;
      else if (ld_val)  val_q <= ld_data;
      else if (inc)     val_q <= val_q + CNT_W'(1);
   end

   assign val_o = val_q;

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld_val && !clr_all) |=> (val_q == $past(val_q) + CNT_W'(1))); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !ld_val && !clr_all) |=> $stable(val_q)); // R5
   AST_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (val_q == '0)); // R9

endmodule

// File: rtl/evc_status.sv
module evc_status #(
   parameter int NUM = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] wrap,
   input  logic [NUM-1:0] set_bits,
   input  logic [NUM-1:0] clr_bits,
   input  logic           clr_all,
   output logic [NUM-1:0] stat_o
);

   logic [NUM-1:0] stat_q;

   // set sources win over a same-edge write-1 clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stat_q <= '0;
      else if (clr_all) stat_q <= '0;
      else              stat_q <= (stat_q & ~clr_bits) | set_bits | wrap;
   end

   assign stat_o = stat_q;

   generate
      for (genvar b = 0; b < NUM; b++) begin : g_chk
         AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[b] && !clr_bits[b] && !clr_all) |=> stat_q[b]); // R7
      end
   endgenerate

endmodule

// File: rtl/evc_irq.sv
module evc_irq #(
   parameter int NUM = 8
) (
   input  logic           gie,
   input  logic [NUM-1:0] stat,
   input  logic [NUM-1:0] ie,
   output logic           irq_o
);

   assign irq_o = gie & (|(stat & ie));

endmodule

// File: rtl/evc_bank.sv
module evc_bank
   import evc_pkg::*;
#(
   parameter int NUM_CNT = 8,
   parameter int CNT_W   = 28,
   parameter int EVT_W   = 32,
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [EVT_W-1:0]  evt_in,
   input  logic              wasted_in,
   output logic              irq
);

   localparam int SEL_W = $clog2(EVT_W);
   localparam int IDX_W = 4;

   generate
      if (NUM_CNT < 3 || NUM_CNT > 16) begin : g_bad_num
         $error("NUM_CNT must lie in 3..16 to fit the register windows");
      end
      if (CNT_W >= DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2 and narrower than DATA_W");
      end
      if ((1 << SEL_W) != EVT_W) begin : g_bad_evt
         $error("EVT_W must be a power of two");
      end
      if (ADDR_W != 12 || DATA_W != 32) begin : g_bad_port
         $error("register port is laid out for 12-bit addresses and 32-bit data");
      end
   endgenerate

   // ---------------- address decode ----------------
   logic [11:0]      word_addr;
   logic [5:0]       win;
   logic [IDX_W-1:0] widx;
   logic             hit_val, hit_ctl, hit_sel;
   logic             unused_low;

   assign word_addr  = {reg_addr[11:2], 2'b00};
   assign win        = reg_addr[11:6];
   assign widx       = reg_addr[5:2];
   assign hit_val    = (win == WIN_VALUE);
   assign hit_ctl    = (win == WIN_CTL);
   assign hit_sel    = (win == WIN_SEL);
   assign unused_low = ^reg_addr[1:0];

   logic we_bctl, we_bclr, we_w1c, we_w1s;
   assign we_bctl = reg_we & (word_addr == OFS_BCTL);
   assign we_bclr = reg_we & (word_addr == OFS_BCLR);
   assign we_w1c  = reg_we & (word_addr == OFS_OVF_W1C);
   assign we_w1s  = reg_we & (word_addr == OFS_OVF_W1S);

   // ---------------- control registers ----------------
   ctl_t                bctl_q;
   ctl_t [NUM_CNT-1:0]  ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bctl_q <= '0;
      else if (we_bctl) bctl_q <= ctl_t'(reg_wdata[1:0]);
   end

   generate
      for (genvar c = 0; c < NUM_CNT; c++) begin : g_ctl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ctl_q[c] <= '0;
            else if (reg_we && hit_ctl && widx == IDX_W'(c))
               ctl_q[c] <= ctl_t'(reg_wdata[1:0]);
         end
      end
   endgenerate

   // ---------------- counter slots ----------------
   logic [NUM_CNT-1:0]            wrap;
   logic [NUM_CNT-1:0]            ie_vec;
   logic [NUM_CNT-1:0][CNT_W-1:0] val;
   logic [NUM_CNT-1:0][SEL_W-1:0] sel;

   generate
      for (genvar c = 0; c < NUM_CNT; c++) begin : g_slot
         logic fixed;
         if (c == 0) begin : g_cyc
            assign fixed = 1'b1;
         end else if (c == 1) begin : g_waste
            assign fixed = wasted_in;
         end else begin : g_none
            assign fixed = 1'b0;
         end

         assign ie_vec[c] = ctl_q[c].ie;

         evc_slot #(
            .CNT_W  (CNT_W),
            .EVT_W  (EVT_W),
            .SEL_W  (SEL_W),
            .HAS_SEL(c >= 2)
         ) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_en   (bctl_q.run & ctl_q[c].run),
            .evt_vec  (evt_in),
            .fixed_evt(fixed),
            .ld_val   (reg_we & hit_val & (widx == IDX_W'(c))),
            .ld_data  (reg_wdata[CNT_W-1:0]),
            .ld_sel   (reg_we & hit_sel & (widx == IDX_W'(c))),
            .sel_data (reg_wdata[SEL_W-1:0]),
            .clr_all  (we_bclr),
            .val_o    (val[c]),
            .sel_o    (sel[c]),
            .wrap_o   (wrap[c])
         );
      end
   endgenerate

   // ---------------- overflow status and interrupt ----------------
   logic [NUM_CNT-1:0] ovf;

   evc_status #(.NUM(NUM_CNT)) status_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap    (wrap),
      .set_bits(we_w1s ? reg_wdata[NUM_CNT-1:0] : '0),
      .clr_bits(we_w1c ? reg_wdata[NUM_CNT-1:0] : '0),
      .clr_all (we_bclr),
      .stat_o  (ovf)
   );

   evc_irq #(.NUM(NUM_CNT)) irq_i (
      .gie  (bctl_q.ie),
      .stat (ovf),
      .ie   (ie_vec),
      .irq_o(irq)
   );

   // ---------------- read path ----------------
   always_comb begin
      reg_rdata = '0;
      if (word_addr == OFS_IDENT) reg_rdata = IDENT_VALUE;
      if (word_addr == OFS_BCTL)  reg_rdata = DATA_W'(bctl_q);
      if (word_addr == OFS_OVF)   reg_rdata = DATA_W'(ovf);
      for (int c = 0; c < NUM_CNT; c++) begin
         if (widx == IDX_W'(c)) begin
            if (hit_val) reg_rdata = {{(DATA_W-CNT_W){1'b0}}, val[c]};
            if (hit_ctl) reg_rdata = DATA_W'(ctl_q[c]);
            if (hit_sel) reg_rdata = DATA_W'(sel[c]);
         end
      end
   end

   // ---------------- assertions ----------------
   generate
      for (genvar c = 0; c < NUM_CNT; c++) begin : g_wrap_chk
         AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            (wrap[c] && !we_bclr) |=> ovf[c]); // R7
      end
   endgenerate

   AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ovf != '0)); // R8
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_vec == '0) |-> !irq); // R5

endmodule

// File: tb/evc_bank_tb.sv
module evc_bank_tb_top;

   localparam logic [31:0] TOPV = 32'h0FFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] evt_in = '0;
   logic        wasted_in = 1'b0;
   logic        irq;

   int n_checks = 0;
   int n_bad    = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   evc_bank dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .evt_in   (evt_in),
      .wasted_in(wasted_in),
      .irq      (irq)
   );

   function automatic logic [11:0] a_val(int n);  return 12'h040 + 12'(4*n); endfunction
   function automatic logic [11:0] a_ctl(int n);  return 12'h100 + 12'(4*n); endfunction
   function automatic logic [11:0] a_sel(int n);  return 12'h140 + 12'(4*n); endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   // starts and ends at a falling edge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 20000);
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R10 reset state
      chk("R10 irq", {31'd0, irq}, 32'd0);
      rdchk("R10 bank ctl", 12'h008, 32'd0);
      rdchk("R10 status", 12'h030, 32'd0);
      for (int n = 0; n < 8; n++) begin
         rdchk("R10 value", a_val(n), 32'd0);
         rdchk("R10 ctl", a_ctl(n), 32'd0);
      end

      // R1 decode
      rdchk("R1 ident", 12'h000, 32'h0001_0000);
      rdchk("R1 ident low bits", 12'h003, 32'h0001_0000);
      rdchk("R1 unmapped 0x004", 12'h004, 32'd0);
      rdchk("R1 unmapped 0x038", 12'h038, 32'd0);
      rdchk("R1 unmapped 0x200", 12'h200, 32'd0);
      rdchk("R1 clear reg", 12'h00C, 32'd0);
      rdchk("R1 set reg", 12'h03C, 32'd0);

      // R6 width
      wr(a_val(2), 32'hFFFF_FFFF);
      rdchk("R6 zero-extend", a_val(2), TOPV);
      wr(a_val(2), 32'd0);

      // R2 run windows
      wr(a_ctl(0), 32'd1);
      rdchk("R1 slot ctl", a_ctl(0), 32'd1);
      for (int m = 0; m < 6; m++) begin
         wr(a_val(0), 32'd0);
         wr(12'h008, 32'd1);
         idle(m);
         wr(12'h008, 32'd0);
         rdchk("R2 cycle count", a_val(0), 32'(m + 1));
      end

      // R5 either run bit low holds the slot
      wr(a_ctl(0), 32'd0);
      wr(a_val(0), 32'd0);
      wr(12'h008, 32'd1);
      idle(4);
      wr(12'h008, 32'd0);
      rdchk("R5 slot run off", a_val(0), 32'd0);
      wr(a_ctl(0), 32'd1);
      idle(4);
      rdchk("R5 bank run off", a_val(0), 32'd0);

      // R3 wasted cycles
      wr(a_ctl(1), 32'd1);
      wr(a_val(1), 32'd0);
      wr(12'h008, 32'd1);
      for (int i = 0; i < 10; i++) begin
         wasted_in = (i % 3) != 0;
         @(negedge clk);
      end
      wasted_in = 1'b0;
      wr(12'h008, 32'd0);
      rdchk("R3 wasted count", a_val(1), 32'd6);

      // R4 selector sweep over every event line
      wr(12'h008, 32'd1);
      for (int n = 2; n < 8; n++) wr(a_ctl(n), 32'd1);
      for (int s = 0; s < 32; s++) begin
         int n = 2 + (s % 6);
         int k = (s % 4) + 1;
         wr(a_sel(n), 32'(s));
         wr(a_val(n), 32'd0);
         for (int j = 0; j < k; j++) begin
            evt_in = 32'd1 << s;
            @(negedge clk);
         end
         evt_in = ~(32'd1 << s);
         idle(2);
         evt_in = '0;
         rdchk("R4 selected count", a_val(n), 32'(k));
         rdchk("R4 selector readback", a_sel(n), 32'(s));
      end
      wr(a_sel(0), 32'h1F);
      rdchk("R4 no selector slot0", a_sel(0), 32'd0);
      wr(a_sel(1), 32'h1F);
      rdchk("R4 no selector slot1", a_sel(1), 32'd0);
      wr(a_sel(6), 32'hFFFF_FFE3);
      rdchk("R4 selector width", a_sel(6), 32'd3);

      // R6 preload distance, R7 status, R8 irq
      wr(12'h008, 32'd3);
      wr(12'h034, 32'hFF);
      wr(a_ctl(3), 32'd3);
      wr(a_sel(3), 32'd7);
      wr(a_val(3), TOPV - 32'd4);
      for (int j = 0; j < 4; j++) begin
         evt_in = 32'd1 << 7;
         @(negedge clk);
      end
      evt_in = '0;
      rdchk("R6 at top", a_val(3), TOPV);
      rdchk("R7 no flag before wrap", 12'h030, 32'd0);
      chk("R8 irq before wrap", {31'd0, irq}, 32'd0);
      evt_in = 32'd1 << 7;
      @(negedge clk);
      evt_in = '0;
      rdchk("R6 wrapped to zero", a_val(3), 32'd0);
      rdchk("R7 flag on wrap", 12'h030, 32'h08);
      chk("R8 irq on wrap", {31'd0, irq}, 32'd1);
      wr(a_ctl(3), 32'd0);
      chk("R5 ctl zero masks irq", {31'd0, irq}, 32'd0);
      rdchk("R7 flag sticky", 12'h030, 32'h08);
      wr(a_ctl(3), 32'd2);
      chk("R8 ie only", {31'd0, irq}, 32'd1);
      wr(12'h008, 32'd1);
      chk("R8 bank ie off", {31'd0, irq}, 32'd0);
      wr(12'h008, 32'd3);
      chk("R8 bank ie on", {31'd0, irq}, 32'd1);
      wr(12'h034, 32'h08);
      rdchk("R7 w1c", 12'h030, 32'd0);
      chk("R8 irq after clear", {31'd0, irq}, 32'd0);

      // R7 set register
      wr(12'h03C, 32'h20);
      rdchk("R7 w1s", 12'h030, 32'h20);
      chk("R8 masked forced bit", {31'd0, irq}, 32'd0);
      wr(a_ctl(5), 32'd3);
      chk("R8 unmasked forced bit", {31'd0, irq}, 32'd1);
      wr(12'h034, 32'h01);
      rdchk("R7 w1c other bit", 12'h030, 32'h20);
      wr(12'h034, 32'h20);
      rdchk("R7 w1c own bit", 12'h030, 32'd0);
      wr(a_ctl(5), 32'd1);

      // R11 same-edge wrap and clear
      wr(a_ctl(4), 32'd1);
      wr(a_sel(4), 32'd1);
      wr(a_val(4), TOPV);
      evt_in = 32'd2;
      wr(12'h034, 32'h10);
      evt_in = '0;
      rdchk("R11 wrap beats clear", 12'h030, 32'h10);
      rdchk("R11 wrapped value", a_val(4), 32'd0);

      // R11 value write beats count (slot 0 running)
      wr(a_val(0), 32'd100);
      rdchk("R11 load beats count", a_val(0), 32'd100);
      @(negedge clk);
      rdchk("R2 counts after load", a_val(0), 32'd101);

      // R9 bank clear
      wr(12'h00C, 32'd0);
      rdchk("R9 slot0 zero", a_val(0), 32'd0);
      rdchk("R9 status zero", 12'h030, 32'd0);
      wr(12'h008, 32'd0);
      for (int n = 1; n < 8; n++) rdchk("R9 slot zero", a_val(n), 32'd0);
      rdchk("R9 ctl kept", a_ctl(3), 32'd2);
      rdchk("R9 selector kept", a_sel(4), 32'd1);

      finish_run();
   end

endmodule